// File: doc/BRIEF.md
# Dual-Copy Registered Command/Address Buffer with Parity Check

This block sits between a memory controller and a module of DDR2 devices. On each rising clock edge it captures a 22-bit command/address word together with two clock-enable bits, two termination-enable bits and two primary chip selects. Every captured bit is then driven on two identical output copies, an A side and a B side, so that each side can feed its own group of DRAM loads.

When a gate-enable input is high and none of the four chip selects is active, the 22-bit address register is not loaded, and its outputs hold their value instead of toggling. The four chip selects are the two primary selects and two extra selects. The clock-enable, termination and chip-select outputs are never gated. Tying the two extra selects high leaves the behaviour identical to a two-select part.

The controller also sends a parity bit with each word. The block checks it for even parity over the 22 address bits on cycles where a chip select is active. It reports a mismatch on an active-low error output one clock after the corresponding word shows on the outputs.

Top module: `ddr_cmd_regbuf`

## Requirements
- R1: While `rst_n` is low, every A and B output reads 0 and `perr_n` reads 1; an asynchronous assertion of `rst_n` clears them without waiting for a clock edge.
- R2: When at least one chip select is active, `addr_qa`/`addr_qb` show the `addr_in` value sampled at the previous rising edge. Chip selects are active low: a bit value of 0 means selected.
- R3: The A and B copies of every output (address, clock enable, termination, chip select) are equal in every cycle.
- R4: When `gate_en` is 1 and all four chip-select inputs (`cs_n_in[1:0]`, `cs_ext_n_in[1:0]`) are 1, the address outputs keep their previous value across the edge.
- R5: When `gate_en` is 0, the address outputs load `addr_in` on every edge, whatever the chip selects are.
- R6: With `gate_en` = 1 and both primary selects at 1, a 0 on either extra select alone enables the address load. Extra selects held at 1 leave behaviour as with primary selects only.
- R7: `cke_q*`, `odt_q*` and `cs_q*` show `cke_in`, `odt_in` and `cs_n_in` from the previous edge, independent of `gate_en` and of chip-select state.
- R8: Parity is even: a word sampled with a chip select active is in error when the XOR of `addr_in[21:0]` and `par_in` is 1. An error drives `perr_n` to 0 for one cycle, starting at the second rising edge after the word was sampled. A correct word leaves `perr_n` at 1 in that cycle.
- R9: A word sampled with no chip select active is not checked: `perr_n` is 1 two edges later even if its parity is wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 22 | Command/address word |
| par_in | input | 1 | Even-parity bit for `addr_in` |
| cke_in | input | 2 | Clock-enable inputs |
| odt_in | input | 2 | Termination-enable inputs |
| cs_n_in | input | 2 | Primary chip selects, active low |
| cs_ext_n_in | input | 2 | Extra chip selects, active low; tie high if unused |
| gate_en | input | 1 | 1 = hold address outputs when no select is active |
| addr_qa | output | 22 | Address copy A |
| addr_qb | output | 22 | Address copy B |
| cke_qa | output | 2 | Clock-enable copy A |
| cke_qb | output | 2 | Clock-enable copy B |
| odt_qa | output | 2 | Termination copy A |
| odt_qb | output | 2 | Termination copy B |
| cs_qa | output | 2 | Primary chip-select copy A |
| cs_qb | output | 2 | Primary chip-select copy B |
| perr_n | output | 1 | Parity error, active low |

## Verification
Every registered output (address, clock enable, termination, chip select) is due one rising edge after its inputs are sampled. The parity flag is due two edges after, which is one edge behind the word it covers. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the following edge. For parity it checks `perr_n` at both the first and the second sample point, so a flag that arrives early or late is caught. Hold cases drive a new word with the selects released, and the check confirms that the previous word stays on both copies while the control outputs still move.

// File: rtl/ddr_cmd_regbuf_pkg.sv
package ddr_cmd_regbuf_pkg;
  localparam int ADDR_W_DEF   = 22;
  localparam int PAIR_W_DEF   = 2;
  localparam int EXT_CS_W_DEF = 2;
  localparam int N_COPY       = 2;

  typedef struct packed {
    logic [PAIR_W_DEF-1:0] cke;
    logic [PAIR_W_DEF-1:0] odt;
    logic [PAIR_W_DEF-1:0] cs_n;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
endpackage

// File: rtl/regbuf_cs_decode.sv
module regbuf_cs_decode #(
  parameter int PRI_W = 2,
  parameter int EXT_W = 2
) (
  input  logic [PRI_W-1:0] cs_n_in,
  input  logic [EXT_W-1:0] cs_ext_n_in,
  input  logic             gate_en,
  output logic             any_sel,
  output logic             addr_load
);
  localparam int ALL_W = PRI_W + EXT_W;
  logic [ALL_W-1:0] sel_vec;

  always_comb begin
    sel_vec   = ~{cs_ext_n_in, cs_n_in};
    any_sel   = |sel_vec;
    addr_load = ~gate_en | any_sel;
  end
endmodule

// File: rtl/regbuf_slice.sv
module regbuf_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data,
  input  logic         par,
  input  logic         eval,
  output logic         perr_n
);
  logic mismatch;
  logic err_s1;

  always_comb mismatch = (^data) ^ par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_s1 <= 1'b0;
      perr_n <= 1'b1;
    end else begin
      err_s1 <= eval & mismatch;
      perr_n <= ~err_s1;
    end
  end
endmodule

// File: rtl/ddr_cmd_regbuf.sv
module ddr_cmd_regbuf
  import ddr_cmd_regbuf_pkg::*;
#(
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int EXT_CS_W = EXT_CS_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic                  par_in,
  input  logic [PAIR_W_DEF-1:0] cke_in,
  input  logic [PAIR_W_DEF-1:0] odt_in,
  input  logic [PAIR_W_DEF-1:0] cs_n_in,
  input  logic [EXT_CS_W-1:0]   cs_ext_n_in,
  input  logic                  gate_en,
  output logic [ADDR_W-1:0]     addr_qa,
  output logic [ADDR_W-1:0]     addr_qb,
  output logic [PAIR_W_DEF-1:0] cke_qa,
  output logic [PAIR_W_DEF-1:0] cke_qb,
  output logic [PAIR_W_DEF-1:0] odt_qa,
  output logic [PAIR_W_DEF-1:0] odt_qb,
  output logic [PAIR_W_DEF-1:0] cs_qa,
  output logic [PAIR_W_DEF-1:0] cs_qb,
  output logic                  perr_n
);
  logic       any_sel;
  logic       addr_load;
  ctrl_word_t ctrl_d;
  logic [ADDR_W-1:0] addr_q [N_COPY];
  ctrl_word_t        ctrl_q [N_COPY];

  always_comb begin
    ctrl_d.cke  = cke_in;
    ctrl_d.odt  = odt_in;
    ctrl_d.cs_n = cs_n_in;
  end

  regbuf_cs_decode #(.PRI_W(PAIR_W_DEF), .EXT_W(EXT_CS_W)) dec_i (
    .cs_n_in(cs_n_in), .cs_ext_n_in(cs_ext_n_in), .gate_en(gate_en),
    .any_sel(any_sel), .addr_load(addr_load)
  );

  for (genvar c = 0; c < N_COPY; c++) begin : g_copy
    regbuf_slice #(.W(ADDR_W)) addr_i (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .d(addr_in), .q(addr_q[c])
    );
    regbuf_slice #(.W(CTRL_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .load(1'b1), .d(ctrl_d), .q(ctrl_q[c])
    );
  end

  regbuf_parity #(.W(ADDR_W)) par_i (
    .clk(clk), .rst_n(rst_n), .data(addr_in), .par(par_in),
    .eval(any_sel), .perr_n(perr_n)
  );

  always_comb begin
    addr_qa = addr_q[0];
    addr_qb = addr_q[1];
    cke_qa  = ctrl_q[0].cke;
    cke_qb  = ctrl_q[1].cke;
    odt_qa  = ctrl_q[0].odt;
    odt_qb  = ctrl_q[1].odt;
    cs_qa   = ctrl_q[0].cs_n;
    cs_qb   = ctrl_q[1].cs_n;
  end
endmodule

// File: rtl/ddr_cmd_regbuf_chk.sv
module ddr_cmd_regbuf_chk #(
  parameter int ADDR_W = 22,
  parameter int PW     = 2,
  parameter int EW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              par_in,
  input logic [PW-1:0]     cke_in,
  input logic [PW-1:0]     odt_in,
  input logic [PW-1:0]     cs_n_in,
  input logic [EW-1:0]     cs_ext_n_in,
  input logic              gate_en,
  input logic [ADDR_W-1:0] addr_qa,
  input logic [ADDR_W-1:0] addr_qb,
  input logic [PW-1:0]     cke_qa,
  input logic [PW-1:0]     cke_qb,
  input logic [PW-1:0]     odt_qa,
  input logic [PW-1:0]     odt_qb,
  input logic [PW-1:0]     cs_qa,
  input logic [PW-1:0]     cs_qb,
  input logic              perr_n
);
  logic sel_now;
  logic bad_par;
  always_comb begin
    sel_now = !((&cs_n_in) && (&cs_ext_n_in));
    bad_par = ^{addr_in, par_in};
  end

  a_r3_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_qa == addr_qb) && (cke_qa == cke_qb) && (odt_qa == odt_qb) && (cs_qa == cs_qb));

  a_r2_load_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now || !gate_en) |=> (addr_qa == $past(addr_in)));

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !sel_now) |=> $stable(addr_qa));

  a_r7_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cke_qa == $past(cke_in)) && (odt_qa == $past(odt_in)) && (cs_qa == $past(cs_n_in)));

  a_r8_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && bad_par) |=> ##1 !perr_n);

  a_r9_parity_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_now || !bad_par) |=> ##1 perr_n);
endmodule

bind ddr_cmd_regbuf ddr_cmd_regbuf_chk #(
  .ADDR_W(ADDR_W), .PW(ddr_cmd_regbuf_pkg::PAIR_W_DEF), .EW(EXT_CS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .par_in(par_in),
  .cke_in(cke_in), .odt_in(odt_in), .cs_n_in(cs_n_in),
  .cs_ext_n_in(cs_ext_n_in), .gate_en(gate_en),
  .addr_qa(addr_qa), .addr_qb(addr_qb), .cke_qa(cke_qa), .cke_qb(cke_qb),
  .odt_qa(odt_qa), .odt_qb(odt_qb), .cs_qa(cs_qa), .cs_qb(cs_qb),
  .perr_n(perr_n)
);

// File: tb/ddr_cmd_regbuf_tb_top.sv
module ddr_cmd_regbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] addr_in;
  logic        par_in;
  logic [1:0]  cke_in, odt_in, cs_n_in, cs_ext_n_in;
  logic        gate_en;
  logic [21:0] addr_qa, addr_qb;
  logic [1:0]  cke_qa, cke_qb, odt_qa, odt_qb, cs_qa, cs_qb;
  logic        perr_n;
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ddr_cmd_regbuf dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .par_in(par_in),
    .cke_in(cke_in), .odt_in(odt_in), .cs_n_in(cs_n_in),
    .cs_ext_n_in(cs_ext_n_in), .gate_en(gate_en),
    .addr_qa(addr_qa), .addr_qb(addr_qb), .cke_qa(cke_qa), .cke_qb(cke_qb),
    .odt_qa(odt_qa), .odt_qb(odt_qb), .cs_qa(cs_qa), .cs_qb(cs_qb),
    .perr_n(perr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic even_par(input logic [21:0] a);
    return ^a;
  endfunction

  task automatic drive(input logic [21:0] a, input logic p, input logic [1:0] ck,
                       input logic [1:0] od, input logic [1:0] cs, input logic [1:0] ex,
                       input logic ge);
    addr_in = a; par_in = p; cke_in = ck; odt_in = od;
    cs_n_in = cs; cs_ext_n_in = ex; gate_en = ge;
  endtask

  task automatic chk_addr(input string tag, input logic [21:0] exp);
    chk(tag, {10'd0, addr_qa}, {10'd0, exp});
    chk({tag, " R3 copyB"}, {10'd0, addr_qb}, {10'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 addr during reset", {10'd0, addr_qa | addr_qb}, 32'd0);
    chk("R1 ctrl during reset", {20'd0, cke_qa, cke_qb, odt_qa, odt_qb, cs_qa, cs_qb}, 32'd0);
    chk("R1 perr_n during reset", {31'd0, perr_n}, 32'd1);
  endtask

  task automatic t_capture();
    logic [21:0] pats [4] = '{22'h3FFFFF, 22'h155555, 22'h2AAAAA, 22'h012345};
    for (int i = 0; i < 4; i++) begin
      drive(pats[i], even_par(pats[i]), 2'(i), 2'(3 - i), 2'b10, 2'b11, 1'b1);
      step();
      chk_addr("R2 capture", pats[i]);
      chk("R7 cke", {30'd0, cke_qa}, 32'(i));
      chk("R7 odt", {30'd0, odt_qb}, 32'(3 - i));
      chk("R7 cs", {28'd0, cs_qa, cs_qb}, 32'hA);
    end
  endtask

  task automatic t_gate_hold();
    drive(22'h0ABCDE, even_par(22'h0ABCDE), 2'b01, 2'b01, 2'b01, 2'b11, 1'b1);
    step();
    chk_addr("R2 before hold", 22'h0ABCDE);
    drive(22'h3F0F0F, 1'b0, 2'b10, 2'b10, 2'b11, 2'b11, 1'b1);
    step();
    chk_addr("R4 hold when idle", 22'h0ABCDE);
    chk("R7 cke while gated", {30'd0, cke_qa}, 32'd2);
    chk("R7 cs while gated", {30'd0, cs_qb}, 32'd3);
    step();
    chk_addr("R4 hold second cycle", 22'h0ABCDE);
  endtask

  task automatic t_no_gate();
    drive(22'h1C3C3C, even_par(22'h1C3C3C), 2'b00, 2'b00, 2'b11, 2'b11, 1'b0);
    step();
    chk_addr("R5 load with gating off", 22'h1C3C3C);
  endtask

  task automatic t_ext_cs();
    drive(22'h222222, even_par(22'h222222), 2'b11, 2'b11, 2'b11, 2'b10, 1'b1);
    step();
    chk_addr("R6 ext select 0", 22'h222222);
    drive(22'h0F0F0F, even_par(22'h0F0F0F), 2'b11, 2'b11, 2'b11, 2'b01, 1'b1);
    step();
    chk_addr("R6 ext select 1", 22'h0F0F0F);
    drive(22'h333333, even_par(22'h333333), 2'b11, 2'b11, 2'b11, 2'b11, 1'b1);
    step();
    chk_addr("R6 ext strapped high holds", 22'h0F0F0F);
  endtask

  task automatic t_parity();
    drive(22'h000001, 1'b0, 2'b00, 2'b00, 2'b10, 2'b11, 1'b1);
    step();
    chk("R8 no flag one edge after", {31'd0, perr_n}, 32'd1);
    drive(22'h000003, 1'b0, 2'b00, 2'b00, 2'b10, 2'b11, 1'b1);
    step();
    chk("R8 flag two edges after", {31'd0, perr_n}, 32'd0);
    step();
    chk("R8 flag clears for good word", {31'd0, perr_n}, 32'd1);
    drive(22'h3FFFFE, 1'b1, 2'b00, 2'b00, 2'b01, 2'b11, 1'b0);
    step();
    step();
    chk("R8 odd-weight word with par=1 ok", {31'd0, perr_n}, 32'd1);
  endtask

  task automatic t_parity_skip();
    drive(22'h000007, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 1'b0);
    step();
    drive(22'h000000, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 1'b0);
    step();
    chk("R9 unselected bad parity ignored", {31'd0, perr_n}, 32'd1);
    chk_addr("R9 word still loaded", 22'h000000);
  endtask

  task automatic t_async_reset();
    drive(22'h2D2D2D, even_par(22'h2D2D2D), 2'b11, 2'b11, 2'b00, 2'b11, 1'b1);
    step();
    rst_n = 1'b0;
    #0.5;
    t_reset();
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(22'h0, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 1'b1);
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    t_capture();
    t_gate_hold();
    t_no_gate();
    t_ext_cs();
    t_parity();
    t_parity_skip();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule